// File: doc/BRIEF.md
# Configurable GPIO Port Controller

This block controls a port of general-purpose pins. Software reaches it over a simple synchronous register bus: an address, a write strobe, write data, and combinational read data. Each pin has four configuration bits: a direction bit, an output latch bit, an open-drain enable and an analog-select bit. From these bits the block computes a per-pin output enable and output value for a tri-state pad. It also samples the pad inputs through one register stage into a readable pin value.

A parameter mask marks which pins can take an analog function. Only those pins hold an analog-select bit. When that bit is set, the pin's digital driver is turned off and its digital read value is forced to zero. A pin in open-drain mode can only pull low. When its latch bit is high, the pin is released.

Register map (three-bit address, one bit per pin in each register): 0 direction, 1 output latch, 2 pin value (a write here goes to the latch), 3 open-drain enable, 4 analog select. Every other address reads as zero.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset, direction reads all ones, latch and open-drain read all zeros, analog select reads equal to the analog-capable mask, and no pad output enable is active.
- R2: With analog select 0 and open-drain 0, a direction bit of 1 gives output enable 0. A direction bit of 0 gives output enable 1 with the output value equal to the latch bit. Writes to address 0 read back unchanged.
- R3: With open-drain 1, analog select 0 and direction 0, a latch bit of 0 gives output enable 1 with output value 0. A latch bit of 1 gives output enable 0. An enabled open-drain pin never outputs 1.
- R4: A pin whose analog-select bit is 1 has output enable 0, whatever its direction, latch and open-drain bits hold.
- R5: A read of address 2 returns the sampled pad level for each pin whose analog-select bit is 0, and 0 for each pin whose analog-select bit is 1.
- R6: Pad inputs pass through exactly one register stage. A pad change made between two rising edges does not appear on a read at address 2 until after the next rising edge.
- R7: A write to address 2 updates the output latch. A read of address 1 returns the latch contents and not the pad level.
- R8: Analog-select bits outside the analog-capable mask read as 0, and writes to them have no effect.
- R9: Reads of addresses 5 to 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | NPIN | Write data |
| bus_rdata | output | NPIN | Read data for bus_addr (combinational) |
| pad_in | input | NPIN | Pad input levels |
| pad_oe | output | NPIN | Per-pin output enable |
| pad_out | output | NPIN | Per-pin output value |

## Verification
Random mixes of the four configuration registers place each pin in every combination of direction, latch, open-drain and analog mode. Comparing the pad outputs against a bench model separates push-pull, open-drain-low, open-drain-released and analog-off behaviour. The bench models the pads with external drive on undriven pins, so pin reads separate the driven level from the external level and show that analog pins read as zero. Directed cases cover three points: a pad change seen before and after the sampling edge, latch reads while the pad disagrees with the latch, and writes of all ones to analog select on pins without analog capability.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int GPIO_AW = 3;

  typedef enum logic [GPIO_AW-1:0] {
    REG_DIR  = 3'd0,
    REG_LAT  = 3'd1,
    REG_PIN  = 3'd2,
    REG_ODN  = 3'd3,
    REG_ASEL = 3'd4
  } gpio_reg_e;
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
  import gpio_pkg::*;
#(
  parameter int               NPIN     = 16,
  parameter logic [NPIN-1:0]  ANA_MASK = '1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [GPIO_AW-1:0] addr,
  input  logic [NPIN-1:0]    wdata,
  output logic [NPIN-1:0]    dir_q,
  output logic [NPIN-1:0]    lat_q,
  output logic [NPIN-1:0]    odn_q,
  output logic [NPIN-1:0]    asel_q
);
  logic dir_en, lat_en, odn_en, asel_en;
  logic [NPIN-1:0] dir_d, lat_d, odn_d, asel_d;

  always_comb begin
    dir_en  = 1'b0;
    lat_en  = 1'b0;
    odn_en  = 1'b0;
    asel_en = 1'b0;
    if (we) begin
      case (gpio_reg_e'(addr))
        REG_DIR:          dir_en  = 1'b1;
        REG_LAT, REG_PIN: lat_en  = 1'b1;
        REG_ODN:          odn_en  = 1'b1;
        REG_ASEL:         asel_en = 1'b1;
        default: ;
      endcase
    end
    dir_d  = dir_en  ? wdata : dir_q;
    lat_d  = lat_en  ? wdata : lat_q;
    odn_d  = odn_en  ? wdata : odn_q;
    asel_d = asel_en ? (wdata & ANA_MASK) : asel_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '1;
      lat_q  <= '0;
      odn_q  <= '0;
      asel_q <= ANA_MASK;
    end else begin
      dir_q  <= dir_d;
      lat_q  <= lat_d;
      odn_q  <= odn_d;
      asel_q <= asel_d;
    end
  end

  // R7
  lat_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && (addr == REG_PIN || addr == REG_LAT)) |=> (lat_q == $past(wdata)));

  // R8
  asel_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == REG_ASEL) |=> ((asel_q & ~ANA_MASK) == '0));
endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive #(
  parameter int NPIN = 16
) (
  input  logic [NPIN-1:0] dir_q,
  input  logic [NPIN-1:0] lat_q,
  input  logic [NPIN-1:0] odn_q,
  input  logic [NPIN-1:0] asel_q,
  output logic [NPIN-1:0] pad_oe,
  output logic [NPIN-1:0] pad_out
);
  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    logic digital_out;
    always_comb begin
      digital_out = ~dir_q[i] & ~asel_q[i];
      pad_oe[i]   = digital_out & (~odn_q[i] | ~lat_q[i]);
      pad_out[i]  = odn_q[i] ? 1'b0 : lat_q[i];
    end
  end
endmodule

// File: rtl/gpio_in_sample.sv
module gpio_in_sample #(
  parameter int NPIN = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] pad_in,
  input  logic [NPIN-1:0] asel_q,
  output logic [NPIN-1:0] pin_val
);
  logic [NPIN-1:0] pad_q;
  logic [NPIN-1:0] pad_d;

  always_comb pad_d = pad_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pad_q <= '0;
    else        pad_q <= pad_d;
  end

  always_comb pin_val = pad_q & ~asel_q;

  // R6
  pad_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (pad_q == $past(pad_in)));
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_pkg::*;
#(
  parameter int              NPIN     = 16,
  parameter logic [NPIN-1:0] ANA_MASK = 16'hF00F,
  parameter int              SYNC_STG = 2
) (
  input  logic               clk,
  input  logic               rst_ni,
  input  logic               bus_we,
  input  logic [GPIO_AW-1:0] bus_addr,
  input  logic [NPIN-1:0]    bus_wdata,
  output logic [NPIN-1:0]    bus_rdata,
  input  logic [NPIN-1:0]    pad_in,
  output logic [NPIN-1:0]    pad_oe,
  output logic [NPIN-1:0]    pad_out
);
  logic rst_n;
  logic [NPIN-1:0] dir_q, lat_q, odn_q, asel_q, pin_val;

  gpio_rst_sync #(.STAGES(SYNC_STG)) u_rst (
    .clk(clk), .rst_ni(rst_ni), .rst_no(rst_n));

  gpio_cfg_regs #(.NPIN(NPIN), .ANA_MASK(ANA_MASK)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr),
    .wdata(bus_wdata), .dir_q(dir_q), .lat_q(lat_q),
    .odn_q(odn_q), .asel_q(asel_q));

  gpio_pad_drive #(.NPIN(NPIN)) u_drive (
    .dir_q(dir_q), .lat_q(lat_q), .odn_q(odn_q), .asel_q(asel_q),
    .pad_oe(pad_oe), .pad_out(pad_out));

  gpio_in_sample #(.NPIN(NPIN)) u_sample (
    .clk(clk), .rst_n(rst_n), .pad_in(pad_in),
    .asel_q(asel_q), .pin_val(pin_val));

  always_comb begin
    case (gpio_reg_e'(bus_addr))
      REG_DIR:  bus_rdata = dir_q;
      REG_LAT:  bus_rdata = lat_q;
      REG_PIN:  bus_rdata = pin_val;
      REG_ODN:  bus_rdata = odn_q;
      REG_ASEL: bus_rdata = asel_q;
      default:  bus_rdata = '0;
    endcase
  end

  // R4
  analog_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & asel_q) == '0);

  // R3
  od_low_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & odn_q & pad_out) == '0);

  // R5
  pin_analog_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == REG_PIN) |-> ((bus_rdata & asel_q) == '0));
endmodule

// File: tb/tb_gpio_port_ctrl.sv
module tb_gpio_port_ctrl;
  localparam int              N    = 16;
  localparam logic [N-1:0]    MASK = 16'hF00F;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic we = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [N-1:0] wdata = '0;
  logic [N-1:0] rdata, oe, pout, pin, ext = '0;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [N-1:0] m_dir, m_lat, m_odn, m_asel;

  always #4 clk = ~clk;

  assign pin = (oe & pout) | (~oe & ext);

  gpio_port_ctrl #(.NPIN(N), .ANA_MASK(MASK)) dut (
    .clk(clk), .rst_ni(rst_ni), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .pad_in(pin),
    .pad_oe(oe), .pad_out(pout));

  function automatic logic [N-1:0] f_oe();
    return ~m_dir & ~m_asel & (~m_odn | ~m_lat);
  endfunction
  function automatic logic [N-1:0] f_out();
    return m_lat & ~m_odn;
  endfunction
  function automatic logic [N-1:0] f_pin();
    logic [N-1:0] e;
    e = f_oe();
    return ((e & f_out()) | (~e & ext)) & ~m_asel;
  endfunction

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
    case (a)
      3'd0: m_dir = d;
      3'd1, 3'd2: m_lat = d;
      3'd3: m_odn = d;
      3'd4: m_asel = d & MASK;
      default: ;
    endcase
  endtask

  task automatic rd(input logic [2:0] a, output logic [N-1:0] v);
    @(negedge clk);
    addr = a;
    #1 v = rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] v;
    int unsigned seed;
    seed = $urandom(32'd2024);
    m_dir = '1; m_lat = '0; m_odn = '0; m_asel = MASK;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(3'd0, v); check("R1 dir", v, '1);
    rd(3'd1, v); check("R1 lat", v, '0);
    rd(3'd3, v); check("R1 odn", v, '0);
    rd(3'd4, v); check("R1 asel", v, MASK);
    check("R1 oe", oe, '0);

    // R9 unmapped reads
    for (int a = 5; a < 8; a++) begin
      rd(3'(a), v); check("R9 unmapped", v, '0);
    end

    // R8 asel writes outside mask ignored
    wr(3'd4, '1);
    rd(3'd4, v); check("R8 asel all ones", v, MASK);
    wr(3'd4, '0);
    rd(3'd4, v); check("R8 asel cleared", v, '0);

    // R2 push-pull outputs
    wr(3'd3, '0);
    wr(3'd1, 16'hA5C3);
    wr(3'd0, 16'h00FF);
    rd(3'd0, v); check("R2 dir readback", v, 16'h00FF);
    check("R2 oe", oe, 16'hFF00);
    check("R2 out", oe & pout, 16'hA500);

    // R3 open drain
    wr(3'd3, 16'hFF00);
    check("R3 oe", oe, 16'h5A00);
    check("R3 out", pout & 16'hFF00, '0);

    // R7 write via pin address, latch read vs pad
    wr(3'd0, '1);
    ext = 16'h0F0F;
    wr(3'd2, 16'h3C3C);
    rd(3'd1, v); check("R7 lat read", v, 16'h3C3C);
    rd(3'd2, v); check("R7 pin read shows pad", v, 16'h0F0F);

    // R6 one-stage sampling
    @(negedge clk);
    addr = 3'd2;
    ext = 16'hF0F0;
    #1 check("R6 before edge", rdata, 16'h0F0F);
    @(negedge clk);
    #1 check("R6 after edge", rdata, 16'hF0F0);

    // R4/R5 analog forces drive off and read zero
    wr(3'd0, '0);
    wr(3'd3, '0);
    wr(3'd4, MASK);
    check("R4 oe analog", oe, ~MASK);
    rd(3'd2, v); check("R5 pin analog zero", v, f_pin());

    // random mixes: R2 R3 R4 R5
    for (int k = 0; k < 300; k++) begin
      logic [2:0] a;
      a = 3'($urandom_range(0, 4));
      ext = N'($urandom);
      wr(a, N'($urandom));
      check("R2/R3/R4 oe random", oe, f_oe());
      check("R2/R3 out random", oe & pout, f_oe() & f_out());
      rd(3'd2, v); check("R5 pin random", v, f_pin());
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule